// File: doc/BRIEF.md
# Frequent-Pattern Block Decompressor

This block rebuilds one 64-byte block, sixteen 32-bit words, from a bit-packed frequent-pattern encoding. The whole encoded block comes in as one wide beat with its bit length. The decompressor then reads it code by code. Each code is a 3-bit prefix followed by a payload whose width depends on the prefix. Each code expands into one full word, except zero-run codes, which expand into several zero words. The reconstructed words leave one per cycle on a valid/ready stream, tagged with their word index.

The input side is a valid/ready port that accepts a new block only while the block is idle. The output side obeys back-pressure: while `out_valid` is high and `out_ready` is low, the word and its index are held unchanged and no decoding state advances. Two plain status pins report the outcome of the most recent block. `done` means all sixteen words were delivered. `error` means the encoding was malformed. Both stay set until the next block is accepted.

Top module: `fp_block_decomp`

## Requirements
- R1: `in_ready` is high exactly when no block is being decoded. A block is taken on a cycle with `in_valid` and `in_ready` both high, and taking it clears `done` and `error`. After reset `in_ready` is 1 and `out_valid`, `done` and `error` are 0.
- R2: Prefix 000 carries a 3-bit count n and produces n+1 zero words, one per accepted output beat.
- R3: Prefix 001 sign-extends a 4-bit payload, prefix 010 an 8-bit payload and prefix 011 a 16-bit payload, each to 32 bits.
- R4: Prefix 100 carries 16 bits that become the upper halfword of the word. The lower halfword is zero.
- R5: Prefix 101 carries two bytes. The first byte is sign-extended into the upper halfword and the second into the lower halfword.
- R6: Prefix 110 carries one byte that is copied into all four byte lanes. Prefix 111 carries the 32-bit word as is.
- R7: The stream is read MSB-first. Its first bit is `in_bits[559]`. Within a code the prefix comes first, then the payload, most significant bit first. Codes follow each other with no gaps.
- R8: Words leave on `out_valid`/`out_ready`. While stalled, `out_data` and `out_index` hold. `out_index` counts 0 to 15 in delivery order.
- R9: `done` rises in the cycle after the handshake of word 15. It stays high until the next block is accepted.
- R10: `error` is set, and output stops, when a zero run would reach beyond word 15 or when a code would extend past `in_len` bits. In the run case, no word of the offending run is delivered. `error` stays high until the next block is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Encoded block offered |
| in_ready | output | 1 | Block can be taken (idle) |
| in_bits | input | 560 | Encoded block, first bit in bit 559 |
| in_len | input | 10 | Number of valid encoded bits |
| out_valid | output | 1 | Reconstructed word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Reconstructed word |
| out_index | output | 4 | Position of the word in the block |
| done | output | 1 | Last block delivered all sixteen words |
| error | output | 1 | Last block was malformed |

## Verification
The assertions assume that `in_len` never exceeds the 560-bit field. They also assume that the consumer may stall for any number of cycles but never resets mid-block. The stimulus keeps within this: every block is built bit by bit in the bench with its exact length. The out-of-range cases come only from deliberate truncation or from zero runs that overshoot the block. Back-pressure is applied with a repeating ready pattern, so the hold rule is exercised while zero runs and single-word codes alternate.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int PFX_W    = 3;
  localparam int FMT_W    = 32;
  localparam int CODE_MAX = PFX_W + FMT_W;
  localparam int CLEN_W   = $clog2(CODE_MAX + 1);
  localparam int RUN_W    = 4;

  typedef enum logic [PFX_W-1:0] {
    PX_ZRUN  = 3'b000,
    PX_SE4   = 3'b001,
    PX_SE8   = 3'b010,
    PX_SE16  = 3'b011,
    PX_HIPAD = 3'b100,
    PX_BPAIR = 3'b101,
    PX_REPB  = 3'b110,
    PX_RAW   = 3'b111
  } prefix_e;

  function automatic logic [CLEN_W-1:0] payload_bits(prefix_e p);
    case (p)
      PX_ZRUN:  return CLEN_W'(3);
      PX_SE4:   return CLEN_W'(4);
      PX_SE8:   return CLEN_W'(8);
      PX_REPB:  return CLEN_W'(8);
      PX_RAW:   return CLEN_W'(32);
      default:  return CLEN_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/fpd_window.sv
module fpd_window #(
  parameter int STREAM_W = 560,
  parameter int POS_W    = 10,
  parameter int OUT_W    = 35
) (
  input  logic [STREAM_W-1:0] stream,
  input  logic [POS_W-1:0]    pos,
  output logic [OUT_W-1:0]    win
);
  logic [STREAM_W-1:0] shifted;

  always_comb begin
    shifted = stream << pos;
    win     = shifted[STREAM_W-1 -: OUT_W];
  end
endmodule

// File: rtl/fpd_expand.sv
module fpd_expand
  import fpd_pkg::*;
(
  input  logic [CODE_MAX-1:0] win,
  output prefix_e             pfx,
  output logic [FMT_W-1:0]    word,
  output logic [CLEN_W-1:0]   code_len,
  output logic [RUN_W-1:0]    run_len
);
  logic [FMT_W-1:0] pl;

  always_comb begin
    pfx      = prefix_e'(win[CODE_MAX-1 -: PFX_W]);
    pl       = win[FMT_W-1:0];
    code_len = CLEN_W'(PFX_W) + payload_bits(pfx);
    run_len  = {1'b0, pl[31:29]} + RUN_W'(1);
    case (pfx)
      PX_ZRUN:  word = '0;
      PX_SE4:   word = {{28{pl[31]}}, pl[31:28]};
      PX_SE8:   word = {{24{pl[31]}}, pl[31:24]};
      PX_SE16:  word = {{16{pl[31]}}, pl[31:16]};
      PX_HIPAD: word = {pl[31:16], 16'h0000};
      PX_BPAIR: word = {{8{pl[31]}}, pl[31:24], {8{pl[23]}}, pl[23:16]};
      PX_REPB:  word = {4{pl[31:24]}};
      default:  word = pl;
    endcase
  end
endmodule

// File: rtl/fp_block_decomp.sv
module fp_block_decomp
  import fpd_pkg::*;
#(
  parameter int BLOCK_WORDS = 16,
  localparam int STREAM_W   = BLOCK_WORDS * CODE_MAX,
  localparam int LEN_W      = $clog2(STREAM_W + 1),
  localparam int IDX_W      = $clog2(BLOCK_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [STREAM_W-1:0] in_bits,
  input  logic [LEN_W-1:0]    in_len,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [FMT_W-1:0]    out_data,
  output logic [IDX_W-1:0]    out_index,
  output logic                done,
  output logic                error
);
  localparam int CNT_W = IDX_W + 2;

  logic                busy_q, done_q, err_q;
  logic [STREAM_W-1:0] stream_q;
  logic [LEN_W-1:0]    len_q, pos_q;
  logic [IDX_W-1:0]    idx_q;
  logic [RUN_W-1:0]    zcnt_q;

  logic [CODE_MAX-1:0] win;
  prefix_e             pfx;
  logic [FMT_W-1:0]    word;
  logic [CLEN_W-1:0]   code_len;
  logic [RUN_W-1:0]    run_len;

  fpd_window #(.STREAM_W(STREAM_W), .POS_W(LEN_W), .OUT_W(CODE_MAX)) u_win (
    .stream(stream_q), .pos(pos_q), .win(win)
  );

  fpd_expand u_exp (
    .win(win), .pfx(pfx), .word(word), .code_len(code_len), .run_len(run_len)
  );

  logic [LEN_W:0] end_pos;
  logic [CNT_W-1:0] run_start, run_end;
  logic too_long, overrun, bad, hs, last_of_code, last_word, take;

  always_comb begin
    end_pos      = {1'b0, pos_q} + (LEN_W+1)'(code_len);
    run_start    = CNT_W'(idx_q) - CNT_W'(zcnt_q);
    run_end      = run_start + CNT_W'(run_len);
    too_long     = end_pos > {1'b0, len_q};
    overrun      = (pfx == PX_ZRUN) && (run_end > CNT_W'(BLOCK_WORDS));
    bad          = busy_q && (too_long || overrun);
    out_valid    = busy_q && !bad;
    hs           = out_valid && out_ready;
    last_of_code = (pfx != PX_ZRUN) || (zcnt_q == run_len - RUN_W'(1));
    last_word    = idx_q == IDX_W'(BLOCK_WORDS - 1);
    in_ready     = !busy_q;
    take         = in_valid && in_ready;
  end

  assign out_data  = word;
  assign out_index = idx_q;
  assign done      = done_q;
  assign error     = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      stream_q <= '0;
      len_q    <= '0;
      pos_q    <= '0;
      idx_q    <= '0;
      zcnt_q   <= '0;
    end else if (take) begin
      busy_q   <= 1'b1;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      stream_q <= in_bits;
      len_q    <= (in_len > LEN_W'(STREAM_W)) ? LEN_W'(STREAM_W) : in_len;
      pos_q    <= '0;
      idx_q    <= '0;
      zcnt_q   <= '0;
    end else if (bad) begin
      busy_q <= 1'b0;
      err_q  <= 1'b1;
    end else if (hs) begin
      idx_q <= idx_q + IDX_W'(1);
      if (last_of_code) begin
        pos_q  <= end_pos[LEN_W-1:0];
        zcnt_q <= '0;
      end else begin
        zcnt_q <= zcnt_q + RUN_W'(1);
      end
      if (last_word) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R2
  zero_run_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pfx == PX_ZRUN) |-> (out_data == '0));

  // R6
  repeat_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pfx == PX_REPB) |-> (out_data == {4{out_data[7:0]}}));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_index)));

  // R8
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !last_word) |=> (out_index == IDX_W'($past(out_index) + IDX_W'(1))));

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(hs && out_index == IDX_W'(BLOCK_WORDS - 1)));

  // R10
  error_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !out_valid);
endmodule

// File: tb/fp_block_decomp_bench.sv
module fp_block_decomp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STREAM_W   = 560;
  localparam int LEN_W      = 10;

  typedef struct packed {
    logic [2:0]  pfx;
    logic [31:0] pay;
    logic [5:0]  plen;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{3'b001, 32'h7,        6'd4,  32'h0000_0007},  // R3
    '{3'b001, 32'h8,        6'd4,  32'hFFFF_FFF8},  // R3
    '{3'b010, 32'h80,       6'd8,  32'hFFFF_FF80},  // R3
    '{3'b010, 32'h7F,       6'd8,  32'h0000_007F},  // R3
    '{3'b011, 32'h8001,     6'd16, 32'hFFFF_8001},  // R3
    '{3'b011, 32'h1234,     6'd16, 32'h0000_1234},  // R3
    '{3'b100, 32'hBEEF,     6'd16, 32'hBEEF_0000},  // R4
    '{3'b101, 32'h807F,     6'd16, 32'hFF80_007F},  // R5
    '{3'b101, 32'h01FE,     6'd16, 32'h0001_FFFE},  // R5
    '{3'b110, 32'hA5,       6'd8,  32'hA5A5_A5A5},  // R6
    '{3'b111, 32'hDEADBEEF, 6'd32, 32'hDEAD_BEEF}   // R6
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [STREAM_W-1:0] in_bits = '0;
  logic [LEN_W-1:0]    in_len = '0;
  logic                out_valid;
  logic                out_ready = 1'b0;
  logic [31:0]         out_data;
  logic [3:0]          out_index;
  logic                done, error;

  int checks = 0;
  int errors = 0;
  logic [STREAM_W-1:0] sbuf;
  int spos;
  logic [31:0] exp_w [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_block_decomp u_fp_block_decomp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .in_len(in_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_index(out_index),
    .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_stream();
    sbuf = '0;
    spos = 0;
  endtask

  task automatic put_bit(input logic b);
    if (spos < STREAM_W) sbuf[STREAM_W-1-spos] = b;
    spos++;
  endtask

  task automatic add_code(input logic [2:0] p, input logic [31:0] v, input int n);
    for (int b = 2; b >= 0; b--) put_bit(p[b]);
    for (int b = n - 1; b >= 0; b--) put_bit(v[b]);
  endtask

  task automatic run_block(input int len, input int nexp, input bit exp_done,
                           input bit exp_err, input bit stall, input string tag);
    int n;
    n = 0;
    @(negedge clk);
    in_bits  = sbuf;
    in_len   = LEN_W'(len);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready && !done && !error, {tag, " R1 busy after take"},
        {29'd0, in_ready, done, error}, 32'd0);
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (done || error) break;
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (out_valid && out_ready) begin
        chk(out_index == 4'(n), {tag, " R8 index"}, {28'd0, out_index}, n);
        chk(out_data == exp_w[n], {tag, " R7 word"}, out_data, exp_w[n]);
        n++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(n == nexp, {tag, " R10 word count"}, n, nexp);
    chk(done == exp_done, {tag, " R9 done"}, {31'd0, done}, {31'd0, exp_done});
    chk(error == exp_err, {tag, " R10 error"}, {31'd0, error}, {31'd0, exp_err});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready && !out_valid && !done && !error, "R1 reset state",
        {28'd0, in_ready, out_valid, done, error}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: sixteen copies of each code (R3 R4 R5 R6)
    for (int v = 0; v < NVEC; v++) begin
      clear_stream();
      for (int k = 0; k < 16; k++) begin
        add_code(VECS[v].pfx, VECS[v].pay, int'(VECS[v].plen));
        exp_w[k] = VECS[v].exp;
      end
      run_block(spos, 16, 1'b1, 1'b0, v[0], $sformatf("vec%0d", v));
    end

    // R9 done held while idle
    repeat (3) @(negedge clk);
    chk(done && !out_valid && in_ready, "R9 done held", {29'd0, done, out_valid, in_ready}, 32'h5);

    // R2 two maximal runs
    clear_stream();
    add_code(3'b000, 32'd7, 3);
    add_code(3'b000, 32'd7, 3);
    for (int k = 0; k < 16; k++) exp_w[k] = 32'h0;
    run_block(spos, 16, 1'b1, 1'b0, 1'b0, "R2 two runs");

    // R2 R7 R8 mixed codes under back-pressure
    clear_stream();
    add_code(3'b000, 32'd2, 3);
    add_code(3'b111, 32'h12345678, 32);
    add_code(3'b000, 32'd7, 3);
    add_code(3'b110, 32'hAA, 8);
    add_code(3'b001, 32'hF, 4);
    add_code(3'b011, 32'h8000, 16);
    add_code(3'b100, 32'h0001, 16);
    for (int k = 0; k < 16; k++) exp_w[k] = 32'h0;
    exp_w[3]  = 32'h12345678;
    exp_w[12] = 32'hAAAAAAAA;
    exp_w[13] = 32'hFFFFFFFF;
    exp_w[14] = 32'hFFFF8000;
    exp_w[15] = 32'h00010000;
    run_block(spos, 16, 1'b1, 1'b0, 1'b1, "R8 mixed stall");

    // R2 run ending exactly at word 15
    clear_stream();
    for (int k = 0; k < 14; k++) begin
      add_code(3'b111, 32'h01010101 * (k + 1), 32);
      exp_w[k] = 32'h01010101 * (k + 1);
    end
    add_code(3'b000, 32'd1, 3);
    exp_w[14] = 32'h0;
    exp_w[15] = 32'h0;
    run_block(spos, 16, 1'b1, 1'b0, 1'b0, "R2 run fits");

    // R10 run overshooting word 15
    clear_stream();
    for (int k = 0; k < 14; k++) add_code(3'b111, 32'h01010101 * (k + 1), 32);
    add_code(3'b000, 32'd2, 3);
    run_block(spos, 14, 1'b0, 1'b1, 1'b0, "R10 run overrun");

    // R10 stream ends at a code boundary too early
    clear_stream();
    for (int k = 0; k < 5; k++) add_code(3'b111, 32'h01010101 * (k + 1), 32);
    run_block(spos, 5, 1'b0, 1'b1, 1'b0, "R10 short stream");

    // R10 length cuts a code in half; R1 clears done on take
    clear_stream();
    for (int k = 0; k < 6; k++) add_code(3'b111, 32'h01010101 * (k + 1), 32);
    run_block(5 * 35 + 20, 5, 1'b0, 1'b1, 1'b1, "R10 cut code");
    repeat (2) @(negedge clk);
    chk(error && !out_valid, "R10 error held", {30'd0, error, out_valid}, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule